// File: doc/BRIEF.md
# Selective LLR Update Decision Unit

This block sits between an iterative soft-in soft-out stage (a detector or a decoder) and its own storage of extrinsic log-likelihood ratios. For every code bit it receives two signed values: the extrinsic LLR kept from the previous iteration and the fresh a-priori LLR for the current one. Their saturated sum stands for the up-to-date a-posteriori value of the bit. When that value is both reliable and consistent with the old value, the old extrinsic LLR may be reused and the expensive recomputation skipped. Reliable means its magnitude is strictly above a threshold. Consistent means its sign matches the sign of the old extrinsic LLR. Otherwise the bit is flagged for recomputation.

Bits stream through a two-stage pipeline with a valid/ready handshake on both sides, one decision per cycle. The threshold is loaded once per iteration through a load strobe. The same strobe clears a counter of reused bits, so the counter tells how many recomputations the current iteration avoided.

Top module: `llr_reuse_gate`

## Requirements
- R1: The sum of the old extrinsic LLR and the a-priori LLR (both LLR_W-bit two's complement) saturates to the range [-2^(LLR_W-1), 2^(LLR_W-1)-1] instead of wrapping.
- R2: A bit is marked for reuse exactly when the magnitude of the saturated sum is strictly greater than the threshold (unsigned, LLR_W bits) and the sign bit of the sum equals the sign bit of the old extrinsic LLR; zero counts as positive.
- R3: While `out_valid` is high, exactly one of `out_reuse` and `out_recompute` is high; while it is low, both are low. `out_llr` equals the old extrinsic LLR on reuse and zero on recompute.
- R4: A pulse on `thr_load` captures `thr_val`; it governs every input accepted on a later cycle, and inputs accepted in the same cycle use the previous threshold.
- R5: An input accepted at clock edge k is presented with `out_valid` high after edge k+1 and not before, when the output side is not stalled.
- R6: While `out_valid` is high and `out_ready` is low, all outputs hold stable; results leave in acceptance order, none lost, and `in_ready` falls once both pipeline stages are full.
- R7: `reuse_count` increments by one for each output transfer with `out_reuse` high and clears to zero on `thr_load`, the clear taking priority.
- R8: After reset `out_valid` is low, `in_ready` is high, `reuse_count` is zero and the threshold is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_load | input | 1 | Load strobe for a new iteration threshold |
| thr_val | input | LLR_W | Threshold value, unsigned |
| in_valid | input | 1 | Input bit pair present |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_old | input | LLR_W | Extrinsic LLR from the previous iteration |
| in_apri | input | LLR_W | A-priori LLR of this iteration |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Consumer takes the decision this cycle |
| out_reuse | output | 1 | Old LLR may be reused |
| out_recompute | output | 1 | Bit needs full recomputation |
| out_llr | output | LLR_W | Forwarded old LLR on reuse, zero otherwise |
| reuse_count | output | CNT_W | Reused bits since the last threshold load |

## Verification
A wrong saturation or sign state shows as a flipped reuse flag on the very decision that carries the affected bit, two edges after it was accepted. A stale threshold register shows on the first bit accepted after a load. A corrupted stall state shows as an output that changes or is dropped while `out_ready` is low, visible in the cycle of the stall. The counter is compared after each burst, so a missed increment or missed clear shows within one transfer.

// File: rtl/llr_gate_pkg.sv
package llr_gate_pkg;

  // Saturating signed add of two W-bit two's-complement values.
  function automatic logic [63:0] sat_add(input logic [63:0] a, input logic [63:0] b,
                                          input int w);
    logic signed [64:0] sa, sb, s, hi, lo;
    sa = 65'(signed'(a << (64 - w))) >>> (64 - w);
    sb = 65'(signed'(b << (64 - w))) >>> (64 - w);
    s  = sa + sb;
    hi = (65'sd1 <<< (w - 1)) - 65'sd1;
    lo = -(65'sd1 <<< (w - 1));
    if (s > hi) s = hi;
    else if (s < lo) s = lo;
    return s[63:0];
  endfunction

endpackage

// File: rtl/llr_sum_stage.sv
module llr_sum_stage #(
  parameter int LLR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             take,
  input  logic [LLR_W-1:0] old_llr,
  input  logic [LLR_W-1:0] apri_llr,
  input  logic [LLR_W-1:0] thr_cur,
  output logic             s1_v,
  output logic [LLR_W-1:0] s1_sum,
  output logic [LLR_W-1:0] s1_old,
  output logic [LLR_W-1:0] s1_thr
);
  import llr_gate_pkg::*;

  logic [63:0] sum_w;

  always_comb begin
    sum_w = sat_add(64'(signed'(old_llr)), 64'(signed'(apri_llr)), LLR_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s1_sum <= '0;
      s1_old <= '0;
      s1_thr <= '0;
    end else if (adv) begin
      s1_v <= take;
      if (take) begin
        s1_sum <= sum_w[LLR_W-1:0];
        s1_old <= old_llr;
        s1_thr <= thr_cur;
      end
    end
  end
endmodule

// File: rtl/llr_decide_stage.sv
module llr_decide_stage #(
  parameter int LLR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             s1_v,
  input  logic [LLR_W-1:0] s1_sum,
  input  logic [LLR_W-1:0] s1_old,
  input  logic [LLR_W-1:0] s1_thr,
  output logic             s2_v,
  output logic             s2_reuse,
  output logic [LLR_W-1:0] s2_llr
);
  logic             sum_neg, old_neg, sign_ok, mag_ok, keep;
  logic [LLR_W-1:0] mag;

  always_comb begin
    sum_neg = s1_sum[LLR_W-1];
    old_neg = s1_old[LLR_W-1];
    mag     = sum_neg ? (~s1_sum + 1'b1) : s1_sum;
    mag_ok  = mag > s1_thr;
    sign_ok = sum_neg == old_neg;
    keep    = mag_ok && sign_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v     <= 1'b0;
      s2_reuse <= 1'b0;
      s2_llr   <= '0;
    end else if (adv) begin
      s2_v     <= s1_v;
      s2_reuse <= s1_v && keep;
      s2_llr   <= (s1_v && keep) ? s1_old : '0;
    end
  end
endmodule

// File: rtl/reuse_tally.sv
module reuse_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/llr_reuse_gate.sv
module llr_reuse_gate #(
  parameter int LLR_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             thr_load,
  input  logic [LLR_W-1:0] thr_val,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LLR_W-1:0] in_old,
  input  logic [LLR_W-1:0] in_apri,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_reuse,
  output logic             out_recompute,
  output logic [LLR_W-1:0] out_llr,
  output logic [CNT_W-1:0] reuse_count
);
  logic [LLR_W-1:0] thr_q;
  logic             s1_v, s2_v, s2_reuse, s1_adv, s2_adv, take;
  logic [LLR_W-1:0] s1_sum, s1_old, s1_thr, s2_llr;

  always_ff @(posedge clk) begin
    if (rst)           thr_q <= '0;
    else if (thr_load) thr_q <= thr_val;
  end

  always_comb begin
    s2_adv   = !s2_v || out_ready;
    s1_adv   = !s1_v || s2_adv;
    in_ready = s1_adv;
    take     = in_valid && s1_adv;
  end

  llr_sum_stage #(.LLR_W(LLR_W)) u_sum (
    .clk(clk), .rst(rst), .adv(s1_adv), .take(take),
    .old_llr(in_old), .apri_llr(in_apri), .thr_cur(thr_q),
    .s1_v(s1_v), .s1_sum(s1_sum), .s1_old(s1_old), .s1_thr(s1_thr)
  );

  llr_decide_stage #(.LLR_W(LLR_W)) u_dec (
    .clk(clk), .rst(rst), .adv(s2_adv),
    .s1_v(s1_v), .s1_sum(s1_sum), .s1_old(s1_old), .s1_thr(s1_thr),
    .s2_v(s2_v), .s2_reuse(s2_reuse), .s2_llr(s2_llr)
  );

  reuse_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .clr(thr_load),
    .inc(s2_v && s2_reuse && out_ready), .count(reuse_count)
  );

  always_comb begin
    out_valid     = s2_v;
    out_reuse     = s2_v && s2_reuse;
    out_recompute = s2_v && !s2_reuse;
    out_llr       = s2_llr;
  end
endmodule

// File: rtl/llr_reuse_gate_chk.sv
module llr_reuse_gate_chk #(
  parameter int LLR_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             thr_load,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_reuse,
  input logic             out_recompute,
  input logic [LLR_W-1:0] out_llr,
  input logic [CNT_W-1:0] reuse_count
);
  // R3
  flag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({out_reuse, out_recompute}) == 1);

  // R3
  flag_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_reuse && !out_recompute);

  // R3
  recompute_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_recompute |-> out_llr == '0);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_llr) && $stable(out_reuse));

  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !in_ready |=> !in_ready || out_ready);

  // R7
  count_clear_chk: assert property (@(posedge clk) disable iff (rst)
    thr_load |=> reuse_count == '0);

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_reuse && !thr_load |=>
      reuse_count == CNT_W'($past(reuse_count) + 1'b1));
endmodule

bind llr_reuse_gate llr_reuse_gate_chk #(.LLR_W(LLR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .thr_load(thr_load), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_reuse(out_reuse),
  .out_recompute(out_recompute), .out_llr(out_llr), .reuse_count(reuse_count)
);

// File: tb/sim_llr_reuse_gate.sv
`timescale 1ns/1ps
module sim_llr_reuse_gate;
  localparam int W = 8;
  localparam int CW = 16;
  localparam int NV = 10;
  // columns: old, apri, threshold, expected reuse
  localparam int VOLD[NV] = '{10, 10, 10, 10, -20, 0, 0, 100, -100, -128};
  localparam int VAPR[NV] = '{20, 5, 6, -40, -10, 3, -5, 100, -100, -128};
  localparam int VTHR[NV] = '{15, 15, 15, 5, 25, 1, 1, 126, 127, 255};
  localparam int VEXP[NV] = '{1, 0, 1, 0, 1, 1, 0, 1, 1, 0};

  logic clk = 0, rst = 1, thr_load = 0, in_valid = 0, out_ready = 1;
  logic [W-1:0] thr_val = '0, in_old = '0, in_apri = '0;
  logic in_ready, out_valid, out_reuse, out_recompute;
  logic [W-1:0] out_llr;
  logic [CW-1:0] reuse_count;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  llr_reuse_gate #(.LLR_W(W), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .thr_load(thr_load), .thr_val(thr_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_old(in_old), .in_apri(in_apri),
    .out_valid(out_valid), .out_ready(out_ready), .out_reuse(out_reuse),
    .out_recompute(out_recompute), .out_llr(out_llr), .reuse_count(reuse_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_thr(input int t);
    @(negedge clk); thr_load = 1; thr_val = t[W-1:0];
    @(negedge clk); thr_load = 0;
  endtask

  task automatic push(input int o, input int a);
    @(negedge clk); in_valid = 1; in_old = o[W-1:0]; in_apri = a[W-1:0];
    @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R8 reset state
    chk("R8 out_valid", int'(out_valid), 0);
    chk("R8 in_ready", int'(in_ready), 1);
    chk("R8 reuse_count", int'(reuse_count), 0);

    // R1 R2 R3 R4 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      int exp_llr;
      load_thr(VTHR[i]);
      chk("R7 clear on load", int'(reuse_count), 0);
      push(VOLD[i], VAPR[i]);
      @(negedge clk); in_valid = 0;
      chk("R5 not early", int'(out_valid), 0);
      @(negedge clk);
      exp_llr = VEXP[i] ? (VOLD[i] & 8'hFF) : 0;
      chk("R5 valid after two edges", int'(out_valid), 1);
      chk("R2 reuse decision", int'(out_reuse), VEXP[i]);
      chk("R3 recompute flag", int'(out_recompute), 1 - VEXP[i]);
      chk("R3 forwarded llr", int'(out_llr), exp_llr);
      @(negedge clk);
    end

    // R4 threshold taken only by later inputs: load 200 and push same cycle
    load_thr(5);
    @(negedge clk); thr_load = 1; thr_val = 8'd200;
    in_valid = 1; in_old = 8'd40; in_apri = 8'd40;
    @(negedge clk); thr_load = 0; in_old = 8'd41; in_apri = 8'd40;
    @(negedge clk); in_valid = 0;
    chk("R4 same-cycle uses old threshold", int'(out_reuse), 1);
    @(negedge clk);
    chk("R4 later input uses new threshold", int'(out_reuse), 0);
    chk("R4 llr zero", int'(out_llr), 0);
    @(negedge clk);

    // R7 counter over a burst: 3 reuses out of 4
    load_thr(5);
    push(10, 10); push(10, -20); push(-10, -10); push(20, 0);
    @(negedge clk); in_valid = 0;
    repeat (4) @(negedge clk);
    chk("R7 reuse_count after burst", int'(reuse_count), 3);
    @(negedge clk); thr_load = 1; thr_val = 8'd9;
    @(negedge clk); thr_load = 0;
    chk("R7 count cleared", int'(reuse_count), 0);

    // R6 backpressure
    out_ready = 0;
    load_thr(0);
    push(33, 1); push(-44, -1);
    @(negedge clk); in_valid = 0;
    chk("R6 in_ready low when full", int'(in_ready), 0);
    chk("R6 head valid", int'(out_valid), 1);
    chk("R6 head value", int'(out_llr), 33);
    repeat (3) @(negedge clk);
    chk("R6 head held", int'(out_llr), 33);
    chk("R6 no count while stalled", int'(reuse_count), 0);
    out_ready = 1;
    @(negedge clk);
    chk("R6 second in order", int'(out_llr), 212);
    chk("R6 second valid", int'(out_valid), 1);
    @(negedge clk);
    chk("R6 drained", int'(out_valid), 0);
    chk("R7 count after drain", int'(reuse_count), 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule